// File: doc/BRIEF.md
# Address Breakpoint Comparator

This block is a single hardware breakpoint unit for a 16-bit processor. It watches two address streams at once: the instruction-fetch address and the data-bus address with its read and write strobes. The unit holds two match addresses that are compared independently but share one control setting. A single control word sets whether the unit is enabled. It also chooses whether the unit watches instruction fetches or data accesses, and, for data accesses, whether reads, writes or both count as a hit. Loading the same value into both address registers gives a single-address breakpoint.

Each hit sets a sticky flag in a status register. There is one flag for each address and each access kind. The same hit also raises a halt request for one cycle. A debug agent reaches the control, status and address registers through a small register port. Status flags are cleared by writing ones to them. Both address registers read back what was written, so software can probe whether a unit is present. Acting on the halt request, and combining several units, is left to the surrounding logic.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, all four registers (select 0 control, 1 status, 2 first address, 3 second address) read as zero and halt_req is low.
- R2: The control register keeps only its four low bits: bit 0 arms data reads, bit 1 arms data writes, bit 2 enables the unit, and bit 3 picks fetch mode. The upper bits are written as ignored and read as zero.
- R3: Both address registers store and return the full 16-bit value written to them.
- R4: In data mode with the unit enabled and bit 0 set, a bus read at either stored address sets status bit 0 (for the first address) or bit 2 (for the second). It also drives halt_req high for exactly the one cycle after the access.
- R5: In data mode with the unit enabled and bit 1 set, a bus write at either stored address sets status bit 1 (first address) or bit 3 (second address), and pulses halt_req.
- R6: A data access whose kind is not armed in the control register produces no status bit and no halt request.
- R7: In fetch mode with the unit enabled, a fetch at the first address sets status bit 4, and a fetch at the second sets bit 5, with a halt pulse. Data reads and writes are ignored in fetch mode, even when control bits 0 and 1 are set.
- R8: In data mode, instruction fetches never produce a hit.
- R9: With the enable bit clear, no access of any kind produces a hit. A control value of zero marks the unit as free.
- R10: Status bits are sticky. They stay set through idle cycles until they are cleared.
- R11: Writing the status register clears exactly the bits written as one. Writing 0xFF clears every flag.
- R12: When a hit and a status clear happen in the same cycle, the hit's flag ends up set.
- R13: With both address registers holding the same value, one matching access sets the flags for both addresses and gives a single one-cycle halt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 first address, 3 second address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value, registered one cycle after the select |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| bus_rd | input | 1 | Data read strobe |
| bus_wr | input | 1 | Data write strobe |
| bus_addr | input | 16 | Data access address |
| halt_req | output | 1 | One-cycle halt request after each hit |

## Verification
The hardest case to reach is a status clear and a new hit landing in the very same clock edge. The bench reaches it by driving the register write strobe and a matching bus read together in one cycle, then reading status back. A second awkward case is the one where both comparators fire on one access. The bench sets up that case by loading the two address registers with the same value before issuing a single read. Mode exclusion is checked by arming every data qualifier while in fetch mode, so that the only thing blocking the hit is the mode bit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // Control word, bit 3 down to bit 0
  typedef struct packed {
    logic fetch_mode;  // 1: match instruction fetches, 0: match data accesses
    logic enable;      // unit armed
    logic brk_wr;      // data writes qualify
    logic brk_rd;      // data reads qualify
  } bkpt_ctl_t;

  localparam int CTL_W         = 4;
  localparam int SEL_CTL       = 0;
  localparam int SEL_STAT      = 1;
  localparam int SEL_ADDR_BASE = 2;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 2,
  parameter int SEL_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_we,
  input  logic [SEL_W-1:0]               reg_sel,
  input  logic [DATA_W-1:0]              reg_wdata,
  output bkpt_ctl_t                      ctl_q,
  output logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q
);

  localparam logic [SEL_W-1:0] CTL_SEL = SEL_W'(SEL_CTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (reg_we && reg_sel == CTL_SEL) begin
      ctl_q <= bkpt_ctl_t'(reg_wdata[CTL_W-1:0]);
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_addr
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(SEL_ADDR_BASE + i);
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i] <= '0;
      end else if (reg_we && reg_sel == MY_SEL) begin
        addr_q[i] <= reg_wdata[ADDR_W-1:0];
      end
    end
  end

  // R3: a write to an address register is visible on the next cycle
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    localparam logic [SEL_W-1:0] CHK_SEL = SEL_W'(SEL_ADDR_BASE + i);
    p_addr_load_r3: assert property (@(posedge clk) disable iff (rst)
      (reg_we && reg_sel == CHK_SEL) |=> (addr_q[i] == $past(reg_wdata[ADDR_W-1:0])));
  end

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_CMP = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  bkpt_ctl_t                      ctl,
  input  logic [NUM_CMP-1:0][ADDR_W-1:0] addr,
  input  logic                           fetch_valid,
  input  logic [ADDR_W-1:0]              fetch_addr,
  input  logic                           bus_rd,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  output logic [NUM_CMP-1:0]             rd_hit,
  output logic [NUM_CMP-1:0]             wr_hit,
  output logic [NUM_CMP-1:0]             fe_hit
);

  logic data_arm;
  logic fetch_arm;

  assign data_arm  = ctl.enable && !ctl.fetch_mode;
  assign fetch_arm = ctl.enable &&  ctl.fetch_mode;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic bus_eq;
    logic fe_eq;
    assign bus_eq    = (bus_addr == addr[i]);
    assign fe_eq     = (fetch_addr == addr[i]);
    assign rd_hit[i] = data_arm && ctl.brk_rd && bus_rd && bus_eq;
    assign wr_hit[i] = data_arm && ctl.brk_wr && bus_wr && bus_eq;
    assign fe_hit[i] = fetch_arm && fetch_valid && fe_eq;
  end

  // R7/R8: fetch hits and data hits never coexist
  p_mode_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !((|fe_hit) && ((|rd_hit) || (|wr_hit))));

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int STAT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status_q,
  output logic              halt_q
);

  logic [STAT_W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      halt_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_eff) | set_vec;
      halt_q   <= |set_vec;
    end
  end

  // R10: without a clear, no flag ever drops
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R11: a clear with no concurrent hit leaves the masked bits at zero
  p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_vec == '0) |=> ((status_q & $past(clr_mask)) == '0));

  // R12: a hit's flag is set on the next cycle whatever the clear does
  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 2,
  parameter int SEL_W   = $clog2(SEL_ADDR_BASE + NUM_CMP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              halt_req
);

  // Status layout: [2i] read hit, [2i+1] write hit, [2N+i] fetch hit
  localparam int STAT_W = 3 * NUM_CMP;
  localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(SEL_STAT);
  localparam logic [SEL_W-1:0] CTL_SEL  = SEL_W'(SEL_CTL);

  bkpt_ctl_t                      ctl_q;
  logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_CMP-1:0]             rd_hit;
  logic [NUM_CMP-1:0]             wr_hit;
  logic [NUM_CMP-1:0]             fe_hit;
  logic [STAT_W-1:0]              set_vec;
  logic [STAT_W-1:0]              stat_q;
  logic                           stat_clr;
  logic [DATA_W-1:0]              rd_next;
  logic                           unused_wdata;

  assign unused_wdata = ^reg_wdata;

  bkpt_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CMP(NUM_CMP),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .ctl_q    (ctl_q),
    .addr_q   (addr_q)
  );

  bkpt_match #(
    .ADDR_W (ADDR_W),
    .NUM_CMP(NUM_CMP)
  ) u_match (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl_q),
    .addr       (addr_q),
    .fetch_valid(fetch_valid),
    .fetch_addr (fetch_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .rd_hit     (rd_hit),
    .wr_hit     (wr_hit),
    .fe_hit     (fe_hit)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_pack
    assign set_vec[2*i]             = rd_hit[i];
    assign set_vec[2*i+1]           = wr_hit[i];
    assign set_vec[2*NUM_CMP + i]   = fe_hit[i];
  end

  assign stat_clr = reg_we && (reg_sel == STAT_SEL);

  bkpt_status #(
    .STAT_W(STAT_W)
  ) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (stat_clr),
    .clr_mask(reg_wdata[STAT_W-1:0]),
    .status_q(stat_q),
    .halt_q  (halt_req)
  );

  always_comb begin
    rd_next = '0;
    if (reg_sel == CTL_SEL) begin
      rd_next = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
    end else if (reg_sel == STAT_SEL) begin
      rd_next = {{(DATA_W-STAT_W){1'b0}}, stat_q};
    end
    for (int i = 0; i < NUM_CMP; i++) begin
      if (reg_sel == SEL_W'(SEL_ADDR_BASE + i)) begin
        rd_next = DATA_W'(addr_q[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_next;
    end
  end

  // R4: a halt request always comes with a recorded flag
  p_halt_flag_r4: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> (stat_q != '0));

  // R9: a disabled unit raises no halt on the following cycle
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.enable |=> !halt_req);

endmodule

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        halt_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_unit dut (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .fetch_valid(fetch_valid),
    .fetch_addr (fetch_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .halt_req   (halt_req)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd_reg(sel, v);
    check(v, exp, tag);
  endtask

  // kind: 0 read, 1 write, 2 fetch; checks the halt pulse and its end
  task automatic access(input int kind, input logic [15:0] a, input logic exp_halt, input string tag);
    @(negedge clk);
    bus_rd = (kind == 0); bus_wr = (kind == 1); fetch_valid = (kind == 2);
    bus_addr = a; fetch_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; fetch_valid = 1'b0;
    check({15'b0, halt_req}, {15'b0, exp_halt}, {tag, " halt"});
    @(negedge clk);
    check({15'b0, halt_req}, 16'h0, {tag, " halt one cycle"});
  endtask

  task automatic t_reset();
    check({15'b0, halt_req}, 16'h0, "R1 halt after reset");
    expect_reg(2'd0, 16'h0, "R1 ctl");
    expect_reg(2'd1, 16'h0, "R1 status");
    expect_reg(2'd2, 16'h0, "R1 addr0");
    expect_reg(2'd3, 16'h0, "R1 addr1");
  endtask

  task automatic t_regs();
    wr_reg(2'd0, 16'hFFFF);
    expect_reg(2'd0, 16'h000F, "R2 ctl width");
    wr_reg(2'd0, 16'h0000);
    expect_reg(2'd0, 16'h0000, "R2 ctl free");
    wr_reg(2'd2, 16'h1234);
    wr_reg(2'd3, 16'hBEEF);
    expect_reg(2'd2, 16'h1234, "R3 addr0");
    expect_reg(2'd3, 16'hBEEF, "R3 addr1");
  endtask

  task automatic t_read_hits();
    wr_reg(2'd0, 16'h0005);
    access(0, 16'h1234, 1'b1, "R4 read addr0");
    expect_reg(2'd1, 16'h0001, "R4 status bit0");
    repeat (5) @(negedge clk);
    expect_reg(2'd1, 16'h0001, "R10 sticky");
    access(0, 16'hBEEF, 1'b1, "R4 read addr1");
    expect_reg(2'd1, 16'h0005, "R4 status bit2");
    access(0, 16'h5555, 1'b0, "R4 no match");
    wr_reg(2'd1, 16'h00FF);
    expect_reg(2'd1, 16'h0000, "R11 clear all");
  endtask

  task automatic t_write_hits();
    wr_reg(2'd0, 16'h0006);
    access(0, 16'h1234, 1'b0, "R6 read not armed");
    expect_reg(2'd1, 16'h0000, "R6 status");
    access(1, 16'hBEEF, 1'b1, "R5 write addr1");
    expect_reg(2'd1, 16'h0008, "R5 status bit3");
    access(1, 16'h1234, 1'b1, "R5 write addr0");
    expect_reg(2'd1, 16'h000A, "R5 status bit1");
    wr_reg(2'd1, 16'h00FF);
  endtask

  task automatic t_fetch();
    wr_reg(2'd0, 16'h000F);
    access(0, 16'h1234, 1'b0, "R7 read ignored");
    access(1, 16'hBEEF, 1'b0, "R7 write ignored");
    expect_reg(2'd1, 16'h0000, "R7 no data flags");
    access(2, 16'hBEEF, 1'b1, "R7 fetch addr1");
    expect_reg(2'd1, 16'h0020, "R7 status bit5");
    access(2, 16'h1234, 1'b1, "R7 fetch addr0");
    expect_reg(2'd1, 16'h0030, "R7 status bit4");
    wr_reg(2'd1, 16'h0010);
    expect_reg(2'd1, 16'h0020, "R11 partial clear");
    wr_reg(2'd1, 16'h00FF);
    expect_reg(2'd1, 16'h0000, "R11 clear rest");
  endtask

  task automatic t_data_mode_fetch();
    wr_reg(2'd0, 16'h0007);
    access(2, 16'h1234, 1'b0, "R8 fetch in data mode");
    expect_reg(2'd1, 16'h0000, "R8 status");
  endtask

  task automatic t_disabled();
    wr_reg(2'd0, 16'h000B);
    access(0, 16'h1234, 1'b0, "R9 read disabled");
    access(2, 16'hBEEF, 1'b0, "R9 fetch disabled");
    wr_reg(2'd0, 16'h0003);
    access(1, 16'hBEEF, 1'b0, "R9 write disabled");
    expect_reg(2'd1, 16'h0000, "R9 status");
  endtask

  task automatic t_collision();
    wr_reg(2'd0, 16'h0005);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h00FF;
    bus_rd = 1'b1; bus_addr = 16'h1234;
    @(negedge clk);
    reg_we = 1'b0; bus_rd = 1'b0;
    check({15'b0, halt_req}, 16'h1, "R12 halt");
    expect_reg(2'd1, 16'h0001, "R12 set wins");
    wr_reg(2'd1, 16'h00FF);
  endtask

  task automatic t_same_addr();
    wr_reg(2'd2, 16'h4000);
    wr_reg(2'd3, 16'h4000);
    wr_reg(2'd0, 16'h0005);
    access(0, 16'h4000, 1'b1, "R13 shared address");
    expect_reg(2'd1, 16'h0005, "R13 both flags");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_read_hits();
    t_write_hits();
    t_fetch();
    t_data_mode_fetch();
    t_disabled();
    t_collision();
    t_same_addr();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule